// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns a 32-bit PCI bus address into a 34-bit host DMA address. It uses a small set of programmable windows, four by default. Each window has three 64-bit registers: a match base, a size mask and a translated base. Software writes these registers through a simple 64-bit register port. A bus-side requester presents an address with a one-cycle request strobe. The block answers with a done strobe, a hit flag and the translated address.

A window is matched on address bits 30:20. It then maps in one of two ways. In direct mode the bus offset is spliced onto the translated base. In scatter-gather mode the block reads one 64-bit page table entry from memory over a request/response port, and builds the result from that entry and the page offset. When no enabled window matches, the block reports a miss with address zero. While a scatter-gather walk is in progress, the block is busy and refuses new requests.

Top module: `dma_win_xlat`

## Requirements
- R1: After reset all window registers read zero, and `busy_o`, `done_o`, `hit_o` and `mem_req_o` are low.
- R2: The register index is the byte offset `reg_off_i` shifted right by 6, so bits 5:0 are ignored. Indices 0 to 3 are the match bases of windows 0 to 3. Indices 4 to 7 are the size masks. Indices 8 to 11 are the translated bases. A write with `reg_we_i` and `reg_full_i` both high stores the data. `reg_rdata_o` always shows the indexed register. Indices 12 to 15 read zero, and writes to them change nothing.
- R3: A write with `reg_full_i` low (a partial-width access) changes no register.
- R4: Bit 0 of a match base enables the window, and bit 1 selects scatter-gather mode. A window matches when the bus address and the match base agree on every bit in 30:20 where the size mask is 0. Windows are searched from index 0 upward. A window that matches but is disabled is skipped, and the lowest enabled matching window is used.
- R5: In direct mode the offset field is the size mask bits 30:20 ORed with 0xFFFFF. The result takes the bus address inside the offset field and the translated base outside it. `done_o` and `hit_o` are high in the cycle after the accepting clock edge, and `done_o` lasts one cycle.
- R6: When no enabled window matches, `done_o` rises in the cycle after acceptance with `hit_o` low and `dma_addr_o` zero.
- R7: In scatter-gather mode, `mem_req_o` is high for exactly one cycle, the cycle after acceptance. `mem_addr_o` carries the entry address. With F = size mask bits 30:20, that address is (translated base AND NOT((F>>10) OR 0x3FF)) OR ((bus AND (F OR (0x7F<<13))) >> 10).
- R8: In scatter-gather mode the result is ((entry AND NOT 1) << 12) OR bus bits 11:0. `done_o` and `hit_o` are high in the cycle after the clock edge that samples `mem_rvalid_i` high.
- R9: Every translated address and entry address is truncated to 34 bits.
- R10: `busy_o` is high from acceptance of a scatter-gather request until its result appears. A `req_i` seen while `busy_o` is high is ignored and produces no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_full_i | input | 1 | High for a full 64-bit access |
| reg_off_i | input | 10 | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Indexed register contents |
| req_i | input | 1 | Translation request strobe |
| bus_addr_i | input | 32 | PCI bus address |
| busy_o | output | 1 | Scatter-gather walk in progress |
| done_o | output | 1 | Result valid strobe |
| hit_o | output | 1 | Last result came from a window |
| dma_addr_o | output | 34 | Translated address |
| mem_req_o | output | 1 | Page table entry read request |
| mem_addr_o | output | 34 | Page table entry address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Page table entry data |

## Verification
The hardest situation to reach from the ports is a request that arrives during a scatter-gather walk, after the memory request has left but before the entry returns. The stimulus programs a scatter-gather window and starts a walk. It holds back the read response, pulses a second request that falls inside a direct window, and checks that no done strobe appears. It then releases the response and checks that exactly one result comes back, and that it belongs to the first request. Priority is reached with overlapping windows, one of them disabled.

// File: rtl/dma_win_pkg.sv
package dma_win_pkg;
  localparam int unsigned REG_W = 64;
  localparam logic [REG_W-1:0] WIN_FIELD = 64'h0000_0000_7FF0_0000;
  localparam logic [REG_W-1:0] DIR_OFF   = 64'h0000_0000_000F_FFFF;
  localparam logic [REG_W-1:0] SG_TLOW   = 64'h0000_0000_0000_03FF;
  localparam logic [REG_W-1:0] SG_PAGE   = 64'h0000_0000_000F_E000;
  localparam int unsigned SG_SHIFT  = 10;
  localparam int unsigned PTE_SHIFT = 12;

  typedef struct packed {
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] tba;
  } win_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_WAIT} xlat_st_e;
endpackage

// File: rtl/dma_win_regs.sv
module dma_win_regs
  import dma_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  full_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output win_cfg_t [NUM_WIN-1:0] cfg_o
);
  logic wr_ok;
  assign wr_ok = we_i & full_i;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [IDX_W-1:0] I_BASE = IDX_W'(w);
    localparam logic [IDX_W-1:0] I_MASK = IDX_W'(NUM_WIN + w);
    localparam logic [IDX_W-1:0] I_TBA  = IDX_W'(2 * NUM_WIN + w);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[w] <= '0;
      end else if (wr_ok) begin
        if (idx_i == I_BASE) cfg_o[w].base <= wdata_i;
        if (idx_i == I_MASK) cfg_o[w].mask <= wdata_i;
        if (idx_i == I_TBA)  cfg_o[w].tba  <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (idx_i == IDX_W'(w))               rdata_o = cfg_o[w].base;
      if (idx_i == IDX_W'(NUM_WIN + w))     rdata_o = cfg_o[w].mask;
      if (idx_i == IDX_W'(2 * NUM_WIN + w)) rdata_o = cfg_o[w].tba;
    end
  end
endmodule

// File: rtl/dma_win_select.sv
module dma_win_select
  import dma_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned BUS_W   = 32
) (
  input  logic [BUS_W-1:0]       bus_i,
  input  win_cfg_t [NUM_WIN-1:0] cfg_i,
  output logic                   hit_o,
  output win_cfg_t               cfg_o
);
  logic [REG_W-1:0]   bus64;
  logic [NUM_WIN-1:0] use_win;

  assign bus64 = REG_W'(bus_i);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [REG_W-1:0] cmp;
    assign cmp        = ~cfg_i[w].mask & WIN_FIELD;
    assign use_win[w] = (((bus64 ^ cfg_i[w].base) & cmp) == '0) & cfg_i[w].base[0];
  end

  // descending scan: lowest enabled match is written last
  always_comb begin
    hit_o = 1'b0;
    cfg_o = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (use_win[w]) begin
        hit_o = 1'b1;
        cfg_o = cfg_i[w];
      end
    end
  end
endmodule

// File: rtl/dma_win_math.sv
module dma_win_math
  import dma_win_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned PA_W  = 34
) (
  input  win_cfg_t         cfg_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic [PA_W-1:0]  direct_o,
  output logic [PA_W-1:0]  pte_addr_o
);
  logic [REG_W-1:0] bus64, fld, off_m, dir_full, tmask, bmask, pte_full;

  always_comb begin
    bus64    = REG_W'(bus_i);
    fld      = cfg_i.mask & WIN_FIELD;
    off_m    = fld | DIR_OFF;
    dir_full = (cfg_i.tba & ~off_m) | (bus64 & off_m);
    tmask    = ~((fld >> SG_SHIFT) | SG_TLOW);
    bmask    = fld | SG_PAGE;
    pte_full = (cfg_i.tba & tmask) | ((bus64 & bmask) >> SG_SHIFT);
  end

  assign direct_o   = dir_full[PA_W-1:0];
  assign pte_addr_o = pte_full[PA_W-1:0];
endmodule

// File: rtl/dma_win_xlat.sv
module dma_win_xlat
  import dma_win_pkg::*;
#(
  parameter  int unsigned NUM_WIN = 4,
  parameter  int unsigned BUS_W   = 32,
  parameter  int unsigned PA_W    = 34,
  localparam int unsigned IDX_W   = $clog2(4 * NUM_WIN),
  localparam int unsigned OFF_W   = IDX_W + 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_full_i,
  input  logic [OFF_W-1:0] reg_off_i,
  input  logic [63:0]      reg_wdata_i,
  output logic [63:0]      reg_rdata_o,
  input  logic             req_i,
  input  logic [BUS_W-1:0] bus_addr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             hit_o,
  output logic [PA_W-1:0]  dma_addr_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i
);
  win_cfg_t [NUM_WIN-1:0] cfg;
  win_cfg_t               sel_cfg;
  logic                   sel_hit;
  logic [PA_W-1:0]        direct_addr, pte_addr, pte_q;
  logic [BUS_W-1:0]       bus_q;
  logic [REG_W-1:0]       sg_full;
  xlat_st_e               st_q;

  dma_win_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .full_i  (reg_full_i),
    .idx_i   (reg_off_i[OFF_W-1:6]),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  dma_win_select #(.NUM_WIN(NUM_WIN), .BUS_W(BUS_W)) u_sel (
    .bus_i (bus_addr_i),
    .cfg_i (cfg),
    .hit_o (sel_hit),
    .cfg_o (sel_cfg)
  );

  dma_win_math #(.BUS_W(BUS_W), .PA_W(PA_W)) u_math (
    .cfg_i      (sel_cfg),
    .bus_i      (bus_addr_i),
    .direct_o   (direct_addr),
    .pte_addr_o (pte_addr)
  );

  assign sg_full = ((mem_rdata_i & ~REG_W'(1)) << PTE_SHIFT) | REG_W'(bus_q[PTE_SHIFT-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      done_o     <= 1'b0;
      hit_o      <= 1'b0;
      dma_addr_o <= '0;
      bus_q      <= '0;
      pte_q      <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          bus_q <= bus_addr_i;
          if (!sel_hit) begin
            done_o     <= 1'b1;
            hit_o      <= 1'b0;
            dma_addr_o <= '0;
          end else if (sel_cfg.base[1]) begin
            pte_q <= pte_addr;
            st_q  <= ST_MREQ;
          end else begin
            done_o     <= 1'b1;
            hit_o      <= 1'b1;
            dma_addr_o <= direct_addr;
          end
        end
        ST_MREQ: st_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          done_o     <= 1'b1;
          hit_o      <= 1'b1;
          dma_addr_o <= sg_full[PA_W-1:0];
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = (st_q == ST_MREQ);
  assign mem_addr_o = pte_q;
endmodule

// File: rtl/dma_win_xlat_chk.sv
module dma_win_xlat_chk #(
  parameter int unsigned PA_W = 34
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            hit_o,
  input logic [PA_W-1:0] dma_addr_o,
  input logic            mem_req_o,
  input logic            mem_rvalid_i
);
  a_r7_memreq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r10_memreq_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r6_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (dma_addr_o == '0));

  a_r5_answer_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> (done_o || mem_req_o));

  a_r8_resp_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_req_o && mem_rvalid_i) |=> (done_o && hit_o && !busy_o));

  a_r10_no_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

bind dma_win_xlat dma_win_xlat_chk #(.PA_W(PA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .hit_o        (hit_o),
  .dma_addr_o   (dma_addr_o),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/tb_dma_win_xlat.sv
`timescale 1ns/1ps
module tb_dma_win_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_full = 1'b1;
  logic [9:0]  reg_off = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        req = 1'b0;
  logic [31:0] bus = '0;
  logic        busy, done, hit, mem_req;
  logic [33:0] dma_addr, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_win_xlat dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_full_i(reg_full),
    .reg_off_i(reg_off), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_i(req), .bus_addr_i(bus), .busy_o(busy), .done_o(done), .hit_o(hit),
    .dma_addr_o(dma_addr), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  typedef struct packed {
    logic [31:0] bus;
    logic [33:0] exp;
  } vec_t;

  // direct translations with all four windows programmed (W3 enabled)
  localparam vec_t VECS [6] = '{
    '{32'h4001_2345, 34'h2_1201_2345},  // R4 W0 matches but disabled, W1 used
    '{32'h4012_3456, 34'h2_1212_3456},  // R5
    '{32'h403F_FFFF, 34'h2_123F_FFFF},  // R5 top of W1
    '{32'h4040_0000, 34'h3_C040_0000},  // R4 falls through to W3
    '{32'h8000_0010, 34'h3_8000_0010},  // R9 bit 31 outside compare, upper tba cut
    '{32'h0000_0000, 34'h3_8000_0000}   // R9
  };

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] d, input logic full);
    @(negedge clk);
    reg_we = 1'b1; reg_full = full; reg_off = 10'(idx << 6); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_full = 1'b1;
  endtask

  task automatic rd(input int idx, output logic [63:0] d);
    reg_off = 10'((idx << 6) | 6'h15);
    #0.5 d = reg_rdata;
  endtask

  task automatic xlat(input logic [31:0] b);
    @(negedge clk);
    req = 1'b1; bus = b;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(20000 * 5.0);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 done", 64'(done), 0);
    check("R1 busy", 64'(busy), 0);
    check("R1 hit", 64'(hit), 0);
    check("R1 mem_req", 64'(mem_req), 0);
    for (int i = 0; i < 12; i++) begin
      rd(i, d);
      check("R1 reg zero", d, 0);
    end

    // program windows; W3 left disabled for the miss test
    wr(0, 64'h4000_0000, 1'b1);
    wr(1, 64'h4000_0001, 1'b1);
    wr(5, 64'h0030_0000, 1'b1);
    wr(9, 64'h2_1230_0000, 1'b1);
    wr(2, 64'h0800_0003, 1'b1);
    wr(6, 64'h0070_0000, 1'b1);
    wr(10, 64'h1_0000, 1'b1);
    wr(7, 64'h7FF0_0000, 1'b1);
    wr(11, 64'hFFFF_FFFF_8000_0000, 1'b1);

    rd(5, d);  check("R2 mask readback", d, 64'h0030_0000);
    rd(11, d); check("R2 tba readback", d, 64'hFFFF_FFFF_8000_0000);
    wr(13, 64'hAAAA_5555, 1'b1);
    rd(13, d); check("R2 unused index reads zero", d, 0);
    rd(1, d);  check("R2 unused write no effect", d, 64'h4000_0001);

    wr(1, 64'hDEAD_BEEF, 1'b0);
    rd(1, d);  check("R3 partial write ignored", d, 64'h4000_0001);

    // R6 miss
    xlat(32'h0000_0000);
    check("R6 done", 64'(done), 1);
    check("R6 hit low", 64'(hit), 0);
    check("R6 addr zero", 64'(dma_addr), 0);

    wr(3, 64'h1, 1'b1);

    foreach (VECS[i]) begin
      xlat(VECS[i].bus);
      check("R5 done", 64'(done), 1);
      check("R4 hit", 64'(hit), 1);
      check("R5 addr", 64'(dma_addr), 64'(VECS[i].exp));
    end
    @(negedge clk);
    check("R5 done one cycle", 64'(done), 0);

    // R7/R8/R10 scatter-gather with refused request
    xlat(32'h0812_3ABC);
    check("R7 mem_req", 64'(mem_req), 1);
    check("R7 pte addr", 64'(mem_addr), 64'h1_0488);
    check("R10 busy", 64'(busy), 1);
    check("R8 no early done", 64'(done), 0);
    xlat(32'h4012_3456);
    check("R7 mem_req single", 64'(mem_req), 0);
    check("R10 refused no done", 64'(done), 0);
    check("R10 still busy", 64'(busy), 1);
    @(negedge clk);
    check("R10 refused no done later", 64'(done), 0);
    mem_rvalid = 1'b1; mem_rdata = 64'h1_2345;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    check("R8 done", 64'(done), 1);
    check("R8 hit", 64'(hit), 1);
    check("R8 sg addr", 64'(dma_addr), 64'h1234_4ABC);
    check("R10 busy cleared", 64'(busy), 0);
    @(negedge clk);
    check("R10 single result", 64'(done), 0);

    // R9 truncation through scatter-gather
    xlat(32'h0800_0FFF);
    check("R7 pte addr base", 64'(mem_addr), 64'h1_0000);
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 64'h3_FFFF_FFFF;
    @(negedge clk);
    mem_rvalid = 1'b0;
    check("R9 sg truncated", 64'(dma_addr), 64'h3_FFFF_EFFF);
    check("R8 done second", 64'(done), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule